// File: doc/BRIEF.md
# Partial-Word Load Merge Unit

This unit forms the new value of a destination register for two partial loads that together read a 32-bit word at an address that is not word-aligned. The unit receives four inputs: the operation, the byte address, the aligned memory word that holds the addressed byte, and the current register value. From these it produces the merged result in the same cycle. Only the bytes of that one aligned word are used, so neither operation ever needs data from the next word.

The upper-fill operation copies the addressed byte, and every byte below it in its word, into the top of the register. The lower-fill operation copies the addressed byte, and every byte above it in its word, into the bottom of the register. Each operation leaves all other register bytes unchanged. Software can issue an upper-fill at the highest address of an unaligned word and a lower-fill at its lowest address, in either order. After both, the register holds the full unaligned word.

The unit has no clock and no state. Its two behaviours are the two values of `op_sel`, and each maps directly from inputs to output.

Top module: `ulm_partial_load_merge`

## Requirements
- R1: With `op_sel` = 0 (upper-fill) and byte offset k = `byte_addr[1:0]`, result byte lane 3-j takes memory byte k-j for j = 0..k. Lane 0 is bits 7:0, and memory byte n is bits 8n+7:8n of `mem_word`.
- R2: With `op_sel` = 0, the result lanes 0 to 2-k equal the same lanes of `reg_in`.
- R3: With `op_sel` = 1 (lower-fill) and offset k, result lane j takes memory byte k+j for j = 0..3-k.
- R4: With `op_sel` = 1, the result lanes 4-k to 3 equal the same lanes of `reg_in`.
- R5: An upper-fill at offset 3, or a lower-fill at offset 0, gives a result equal to `mem_word`.
- R6: Address bits above bit 1 have no effect on the result.
- R7: The result is combinational. It follows its inputs within the same cycle and holds no state.
- R8: Take an upper-fill at byte address 6 on the word that holds bytes 4..7, then a lower-fill at byte address 3 on the word that holds bytes 0..3, with the first result fed back as `reg_in`. The final result is bytes 6,5,4,3 from most to least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 1 | 0 = upper-fill, 1 = lower-fill |
| byte_addr | input | 32 | Byte address of the access; only the low two bits select lanes |
| mem_word | input | 32 | Aligned memory word that contains the addressed byte |
| reg_in | input | 32 | Current destination register value |
| merged_out | output | 32 | Merged register value |

## Verification
Immediate assertions run whenever the inputs change. They check that the lanes to be kept match `reg_in`, that the edge lane (top for upper-fill, bottom for lower-fill) carries the addressed memory byte, and that the two boundary offsets copy the whole word. Full lane placement at every offset depends on the exact byte values. That, the lack of any effect from the upper address bits, and the two-step sequence that assembles an unaligned word can only be shown by the bench's vectors, which compare the result to independently written expected words.

// File: rtl/ulm_pkg.sv
package ulm_pkg;
    typedef enum logic {
        FILL_UPPER = 1'b0,
        FILL_LOWER = 1'b1
    } part_op_e;
endpackage

// File: rtl/ulm_lane_enable.sv
module ulm_lane_enable
    import ulm_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFS_W = 2
) (
    input  part_op_e           op,
    input  logic [OFS_W-1:0]   ofs,
    output logic [LANES-1:0]   take_mem
);
    // One enable per lane: set when the lane receives a memory byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (op == FILL_UPPER)
                take_mem[g] = (g + int'(ofs)) >= (LANES - 1);
            else
                take_mem[g] = (g + int'(ofs)) <= (LANES - 1);
        end
    end

    // The edge lane is always written from memory (R1, R3).
    always_comb begin
        if (!$isunknown({op, ofs})) begin
            if (op == FILL_UPPER) begin
                assert_upper_edge_lane_R1: assert (take_mem[LANES-1])
                    else $error("upper-fill left top lane unwritten");
            end else begin
                assert_lower_edge_lane_R3: assert (take_mem[0])
                    else $error("lower-fill left bottom lane unwritten");
            end
        end
    end
endmodule

// File: rtl/ulm_byte_align.sv
module ulm_byte_align
    import ulm_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int OFS_W  = 2
) (
    input  part_op_e                 op,
    input  logic [OFS_W-1:0]         ofs,
    input  logic [LANES*BYTE_W-1:0]  mem_word,
    output logic [LANES*BYTE_W-1:0]  aligned
);
    // Each lane picks its source byte; out-of-range lanes get zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            int src;
            int src_c;
            if (op == FILL_UPPER)
                src = g - (LANES - 1) + int'(ofs);
            else
                src = g + int'(ofs);
            src_c = (src < 0 || src >= LANES) ? 0 : src;
            if (src < 0 || src >= LANES)
                aligned[g*BYTE_W +: BYTE_W] = '0;
            else
                aligned[g*BYTE_W +: BYTE_W] = mem_word[src_c*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/ulm_lane_merge.sv
module ulm_lane_merge #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic [LANES-1:0]         take_mem,
    input  logic [LANES*BYTE_W-1:0]  aligned,
    input  logic [LANES*BYTE_W-1:0]  reg_in,
    output logic [LANES*BYTE_W-1:0]  merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] = take_mem[g] ? aligned[g*BYTE_W +: BYTE_W]
                                                        : reg_in[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ulm_partial_load_merge.sv
module ulm_partial_load_merge
    import ulm_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32
) (
    input  logic                          op_sel,
    input  logic [ADDR_W-1:0]             byte_addr,
    input  logic [BYTE_W*WORD_BYTES-1:0]  mem_word,
    input  logic [BYTE_W*WORD_BYTES-1:0]  reg_in,
    output logic [BYTE_W*WORD_BYTES-1:0]  merged_out
);
    localparam int DATA_W = BYTE_W * WORD_BYTES;
    localparam int OFS_W  = $clog2(WORD_BYTES);

    part_op_e               op;
    logic [OFS_W-1:0]       ofs;
    logic [WORD_BYTES-1:0]  take_mem;
    logic [DATA_W-1:0]      aligned;
    logic                   unused_addr_hi;

    assign op             = part_op_e'(op_sel);
    assign ofs            = byte_addr[OFS_W-1:0];
    assign unused_addr_hi = ^byte_addr[ADDR_W-1:OFS_W];

    ulm_lane_enable #(.LANES(WORD_BYTES), .OFS_W(OFS_W)) u_enable (
        .op       (op),
        .ofs      (ofs),
        .take_mem (take_mem)
    );

    ulm_byte_align #(.LANES(WORD_BYTES), .BYTE_W(BYTE_W), .OFS_W(OFS_W)) u_align (
        .op       (op),
        .ofs      (ofs),
        .mem_word (mem_word),
        .aligned  (aligned)
    );

    ulm_lane_merge #(.LANES(WORD_BYTES), .BYTE_W(BYTE_W)) u_merge (
        .take_mem (take_mem),
        .aligned  (aligned),
        .reg_in   (reg_in),
        .merged   (merged_out)
    );

    // Output-level checks against the port values.
    always_comb begin
        if (!$isunknown({op_sel, byte_addr, mem_word, reg_in})) begin
            if (op == FILL_UPPER) begin
                assert_top_byte_R1: assert (merged_out[DATA_W-1 -: BYTE_W]
                                            == mem_word[int'(ofs)*BYTE_W +: BYTE_W])
                    else $error("upper-fill top byte wrong");
                for (int g = 0; g < WORD_BYTES; g++) begin
                    if (g + int'(ofs) < WORD_BYTES - 1) begin
                        assert_keep_low_R2: assert (merged_out[g*BYTE_W +: BYTE_W]
                                                    == reg_in[g*BYTE_W +: BYTE_W])
                            else $error("upper-fill altered kept lane %0d", g);
                    end
                end
                if (int'(ofs) == WORD_BYTES - 1) begin
                    assert_full_upper_R5: assert (merged_out == mem_word)
                        else $error("upper-fill at top offset not whole word");
                end
            end else begin
                assert_bottom_byte_R3: assert (merged_out[BYTE_W-1:0]
                                               == mem_word[int'(ofs)*BYTE_W +: BYTE_W])
                    else $error("lower-fill bottom byte wrong");
                for (int g = 0; g < WORD_BYTES; g++) begin
                    if (g + int'(ofs) > WORD_BYTES - 1) begin
                        assert_keep_high_R4: assert (merged_out[g*BYTE_W +: BYTE_W]
                                                     == reg_in[g*BYTE_W +: BYTE_W])
                            else $error("lower-fill altered kept lane %0d", g);
                    end
                end
                if (ofs == '0) begin
                    assert_full_lower_R5: assert (merged_out == mem_word)
                        else $error("lower-fill at offset 0 not whole word");
                end
            end
        end
    end
endmodule

// File: tb/test_ulm_partial_load_merge.sv
module test_ulm_partial_load_merge;
    logic        clk = 1'b0;
    logic        op_sel;
    logic [31:0] byte_addr, mem_word, reg_in, merged_out;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    ulm_partial_load_merge i_ulm_partial_load_merge (
        .op_sel     (op_sel),
        .byte_addr  (byte_addr),
        .mem_word   (mem_word),
        .reg_in     (reg_in),
        .merged_out (merged_out)
    );

    // {op, addr, mem, reg, expected}
    localparam int NVEC = 10;
    localparam logic [128:0] VEC [NVEC] = '{
        {1'b0, 32'h1000_0004, 32'h8877_6655, 32'hAABB_CCDD, 32'h55BB_CCDD},
        {1'b0, 32'h2000_0005, 32'h8877_6655, 32'hAABB_CCDD, 32'h6655_CCDD},
        {1'b0, 32'h3000_0006, 32'h8877_6655, 32'hAABB_CCDD, 32'h7766_55DD},
        {1'b0, 32'h4000_0007, 32'h8877_6655, 32'hAABB_CCDD, 32'h8877_6655},
        {1'b1, 32'h1000_0008, 32'h8877_6655, 32'hAABB_CCDD, 32'h8877_6655},
        {1'b1, 32'h2000_0009, 32'h8877_6655, 32'hAABB_CCDD, 32'hAA88_7766},
        {1'b1, 32'h3000_000A, 32'h8877_6655, 32'hAABB_CCDD, 32'hAABB_8877},
        {1'b1, 32'h4000_000B, 32'h8877_6655, 32'hAABB_CCDD, 32'hAABB_CC88},
        {1'b0, 32'h0000_0006, 32'h1716_1514, 32'hA0B0_C0D0, 32'h1615_14D0},
        {1'b1, 32'h0000_0003, 32'h1312_1110, 32'h1615_14D0, 32'h1615_1413}
    };

    task automatic apply(input logic op, input logic [31:0] a, m, r);
        @(negedge clk);
        op_sel = op; byte_addr = a; mem_word = m; reg_in = r;
        #5;
    endtask

    task automatic check(input string req, input logic [31:0] exp);
        n_checks++;
        if (merged_out !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, merged_out, exp);
        end
    endtask

    initial begin
        op_sel = 1'b0; byte_addr = '0; mem_word = '0; reg_in = '0;
        #5;
        check("R7 idle inputs", 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][128], VEC[i][127:96], VEC[i][95:64], VEC[i][63:32]);
            if (i == 3 || i == 4)      check("R5 full word", VEC[i][31:0]);
            else if (i >= 8)           check("R8 unaligned pair", VEC[i][31:0]);
            else if (VEC[i][128] == 0) check("R1 R2 upper-fill", VEC[i][31:0]);
            else                       check("R3 R4 lower-fill", VEC[i][31:0]);
        end

        apply(1'b0, 32'hFFFF_FFF1, 32'h8877_6655, 32'hAABB_CCDD);
        check("R6 high address bits set", 32'h6655_CCDD);
        apply(1'b0, 32'h0000_0001, 32'h8877_6655, 32'hAABB_CCDD);
        check("R6 high address bits clear", 32'h6655_CCDD);

        mem_word = 32'h0102_0304;
        #1;
        check("R7 same-cycle update", 32'h0304_CCDD);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule